// File: doc/BRIEF.md
# Noncacheable Load Read-Request Splitter

This block sits between a load unit and an AXI read address channel. It takes one noncacheable load request and turns it into one or two read address transactions. A request names the access kind (byte, halfword, word, two-register or doubleword, three-register), a byte address and a flag that says whether the target is strongly-ordered or device memory. The alternative to that flag is normal noncacheable memory, or a cache that is switched off. For each transaction the block works out the start address, burst type, beat size and beat count.

Misaligned halfword and word loads become a fixed pair of narrower reads. Multi-register loads pick their beat size from the memory type. A multi-register load that would run past the end of the aligned line is split, and its second part restarts at the line base. The pieces go out in order through a valid/ready handshake. A one-cycle completion pulse reports how many transactions were used. Returned data and its merging belong to other logic.

Top module: `nc_load_splitter`

## Requirements
- R1: Kind code 0 (byte), and the unused codes 5, 6 and 7, produce one transaction at the exact request address with size code 0 (8-bit) and length 0.
- R2: Kind code 1 (halfword) uses the byte position within the word, address bits [1:0]. Position 0 or 2 gives one 16-bit beat (size 1). Position 1 gives one 32-bit beat (size 2). Both of these are at the exact address. Position 3 gives an 8-bit beat at the address, then an 8-bit beat at the word-aligned address plus 4.
- R3: Kind code 2 (word) also decodes address bits [1:0]. Position 0 gives one 32-bit beat. Position 1 gives 32-bit, then 8-bit. Position 2 gives 16-bit, then 16-bit. Position 3 gives 8-bit, then 32-bit. In every two-part case the second transaction is at the word-aligned address plus 4.
- R4: Kind code 3 (two-register) starts at the word-aligned address. On an even word of the 32-byte line (address bits [4:2]) it is one 64-bit beat (size 3, length 0). On an odd word other than 7 it is a 32-bit burst of two beats (length 1).
- R5: Kind code 3 on word 7 becomes a 32-bit single beat at line offset 0x1C, then a 32-bit single beat at the line base. The bits above [4:0] are kept.
- R6: Kind code 4 (three-register) on words 0 to 5 is one transaction at the word-aligned address. When req_strict is 1 it is a 32-bit burst of three beats (length 2). When req_strict is 0 it is a 64-bit burst of two beats (length 1).
- R7: Kind code 4 on word 6 becomes a 64-bit single beat at offset 0x18, then a 32-bit single beat at the line base. On word 7 it becomes a 32-bit single beat at 0x1C, then a 64-bit single beat at the line base.
- R8: The second transaction is presented only after the first has been accepted (ar_valid and ar_ready high at a clock edge). While ar_valid is high and ar_ready is low, ar_valid and the address, size and length outputs hold steady.
- R9: ar_burst is always 2'b01 (INCR). ar_len always equals the beat count minus one.
- R10: In the cycle after the last transaction is accepted, done is high for one cycle. done_count then holds the number of transactions issued (1 or 2).
- R11: After reset, req_ready is 1 and ar_valid and done are 0. req_ready is high only while no request is in progress, and an accepted request raises ar_valid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_kind | input | 3 | Access kind code |
| req_addr | input | ADDR_W | Byte address of the load |
| req_strict | input | 1 | 1: strongly-ordered or device memory |
| ar_valid | output | 1 | Read address transaction present |
| ar_ready | input | 1 | Read address accepted by the bus |
| ar_addr | output | ADDR_W | Transaction start address |
| ar_burst | output | 2 | Burst type, INCR |
| ar_size | output | 3 | Beat size code |
| ar_len | output | 4 | Beats minus one |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | 2 | Transactions issued, valid with done |

## Verification
On every cycle the assertions check the handshake rules: a stalled transaction holds its values, ar_valid and req_ready are never high together, an accepted request is followed by a transaction, a done pulse follows an accepted transaction, and its count and the length stay in range. Only the bench's scenarios can show that the address, size and length of each piece match the decode tables. The same goes for the order of the two pieces, the wrap to the line base for the word-6 and word-7 cases, and the choice of beat size by memory type. These are covered with directed sweeps of every word and byte position plus random addresses and random bus stalls.

// File: rtl/nc_split_pkg.sv
package nc_split_pkg;

    typedef enum logic [2:0] {
        KIND_BYTE   = 3'd0,
        KIND_HALF   = 3'd1,
        KIND_WORD   = 3'd2,
        KIND_DUAL   = 3'd3,
        KIND_TRIPLE = 3'd4
    } load_kind_e;

    localparam logic [2:0] SZ_8  = 3'd0;
    localparam logic [2:0] SZ_16 = 3'd1;
    localparam logic [2:0] SZ_32 = 3'd2;
    localparam logic [2:0] SZ_64 = 3'd3;

    localparam logic [1:0] BURST_INCR = 2'b01;

    // Shape of one read address transaction
    typedef struct packed {
        logic [2:0] size;
        logic [3:0] len;
    } ar_shape_t;

    function automatic ar_shape_t mk_shape(input logic [2:0] size, input int beats);
        ar_shape_t s;
        s.size = size;
        s.len  = 4'(beats - 1);
        return s;
    endfunction

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_SECOND = 2'd2
    } seq_state_e;

endpackage

// File: rtl/nc_split_decode.sv
module nc_split_decode
    import nc_split_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic [2:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strict,
    output logic [ADDR_W-1:0] first_addr,
    output ar_shape_t         first_shape,
    output logic [ADDR_W-1:0] second_addr,
    output ar_shape_t         second_shape,
    output logic              two_parts
);

    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam int WIDX_W = OFS_W - 2;
    localparam int WORDS  = LINE_BYTES / 4;
    localparam logic [WIDX_W-1:0] LAST_W   = WIDX_W'(WORDS - 1);
    localparam logic [WIDX_W-1:0] PENULT_W = WIDX_W'(WORDS - 2);

    logic [1:0]        bpos;
    logic [WIDX_W-1:0] widx;
    logic [ADDR_W-1:0] word_al;
    logic [ADDR_W-1:0] next_word;
    logic [ADDR_W-1:0] line_base;

    assign bpos      = addr[1:0];
    assign widx      = addr[OFS_W-1:2];
    assign word_al   = {addr[ADDR_W-1:2], 2'b00};
    assign next_word = word_al + ADDR_W'(4);
    assign line_base = {addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

    always_comb begin
        first_addr   = addr;
        first_shape  = mk_shape(SZ_8, 1);
        second_addr  = next_word;
        second_shape = mk_shape(SZ_8, 1);
        two_parts    = 1'b0;
        case (load_kind_e'(kind))
            KIND_HALF: begin
                case (bpos)
                    2'd1:    first_shape = mk_shape(SZ_32, 1);
                    2'd3:    two_parts   = 1'b1;
                    default: first_shape = mk_shape(SZ_16, 1);
                endcase
            end
            KIND_WORD: begin
                case (bpos)
                    2'd0: first_shape = mk_shape(SZ_32, 1);
                    2'd1: begin
                        first_shape = mk_shape(SZ_32, 1);
                        two_parts   = 1'b1;
                    end
                    2'd2: begin
                        first_shape  = mk_shape(SZ_16, 1);
                        second_shape = mk_shape(SZ_16, 1);
                        two_parts    = 1'b1;
                    end
                    default: begin
                        second_shape = mk_shape(SZ_32, 1);
                        two_parts    = 1'b1;
                    end
                endcase
            end
            KIND_DUAL: begin
                first_addr = word_al;
                if (widx == LAST_W) begin
                    first_shape  = mk_shape(SZ_32, 1);
                    second_addr  = line_base;
                    second_shape = mk_shape(SZ_32, 1);
                    two_parts    = 1'b1;
                end else if (widx[0]) begin
                    first_shape = mk_shape(SZ_32, 2);
                end else begin
                    first_shape = mk_shape(SZ_64, 1);
                end
            end
            KIND_TRIPLE: begin
                first_addr  = word_al;
                second_addr = line_base;
                if (widx == PENULT_W) begin
                    first_shape  = mk_shape(SZ_64, 1);
                    second_shape = mk_shape(SZ_32, 1);
                    two_parts    = 1'b1;
                end else if (widx == LAST_W) begin
                    first_shape  = mk_shape(SZ_32, 1);
                    second_shape = mk_shape(SZ_64, 1);
                    two_parts    = 1'b1;
                end else if (strict) begin
                    first_shape = mk_shape(SZ_32, 3);
                end else begin
                    first_shape = mk_shape(SZ_64, 2);
                end
            end
            default: begin
                first_addr = addr;
            end
        endcase
    end

endmodule

// File: rtl/nc_split_seq.sv
module nc_split_seq
    import nc_split_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] first_addr,
    input  ar_shape_t         first_shape,
    input  logic [ADDR_W-1:0] second_addr,
    input  ar_shape_t         second_shape,
    input  logic              two_parts,
    output logic              ar_valid,
    input  logic              ar_ready,
    output logic [ADDR_W-1:0] ar_addr,
    output ar_shape_t         ar_shape,
    output logic              done,
    output logic [1:0]        done_count
);

    seq_state_e        state;
    logic [ADDR_W-1:0] cur_addr;
    ar_shape_t         cur_shape;
    logic [ADDR_W-1:0] pend_addr;
    ar_shape_t         pend_shape;
    logic              pend_valid;
    logic              accept;
    logic              fire;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign ar_valid  = (state != ST_IDLE);
    assign fire      = ar_valid && ar_ready;
    assign ar_addr   = cur_addr;
    assign ar_shape  = cur_shape;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cur_addr   <= '0;
            cur_shape  <= '0;
            pend_addr  <= '0;
            pend_shape <= '0;
            pend_valid <= 1'b0;
            done       <= 1'b0;
            done_count <= 2'd0;
        end else begin
            done       <= 1'b0;
            done_count <= 2'd0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cur_addr   <= first_addr;
                        cur_shape  <= first_shape;
                        pend_addr  <= second_addr;
                        pend_shape <= second_shape;
                        pend_valid <= two_parts;
                        state      <= ST_FIRST;
                    end
                end
                ST_FIRST: begin
                    if (fire) begin
                        if (pend_valid) begin
                            cur_addr  <= pend_addr;
                            cur_shape <= pend_shape;
                            state     <= ST_SECOND;
                        end else begin
                            done       <= 1'b1;
                            done_count <= 2'd1;
                            state      <= ST_IDLE;
                        end
                    end
                end
                ST_SECOND: begin
                    if (fire) begin
                        done       <= 1'b1;
                        done_count <= 2'd2;
                        pend_valid <= 1'b0;
                        state      <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nc_load_splitter.sv
module nc_load_splitter
    import nc_split_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_strict,
    output logic              ar_valid,
    input  logic              ar_ready,
    output logic [ADDR_W-1:0] ar_addr,
    output logic [1:0]        ar_burst,
    output logic [2:0]        ar_size,
    output logic [3:0]        ar_len,
    output logic              done,
    output logic [1:0]        done_count
);

    logic [ADDR_W-1:0] dec_first_addr;
    logic [ADDR_W-1:0] dec_second_addr;
    ar_shape_t         dec_first_shape;
    ar_shape_t         dec_second_shape;
    logic              dec_two;
    ar_shape_t         out_shape;

    nc_split_decode #(
        .ADDR_W    (ADDR_W),
        .LINE_BYTES(LINE_BYTES)
    ) u_decode (
        .kind        (req_kind),
        .addr        (req_addr),
        .strict      (req_strict),
        .first_addr  (dec_first_addr),
        .first_shape (dec_first_shape),
        .second_addr (dec_second_addr),
        .second_shape(dec_second_shape),
        .two_parts   (dec_two)
    );

    nc_split_seq #(
        .ADDR_W(ADDR_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .first_addr  (dec_first_addr),
        .first_shape (dec_first_shape),
        .second_addr (dec_second_addr),
        .second_shape(dec_second_shape),
        .two_parts   (dec_two),
        .ar_valid    (ar_valid),
        .ar_ready    (ar_ready),
        .ar_addr     (ar_addr),
        .ar_shape    (out_shape),
        .done        (done),
        .done_count  (done_count)
    );

    assign ar_burst = BURST_INCR;
    assign ar_size  = out_shape.size;
    assign ar_len   = out_shape.len;

endmodule

// File: rtl/nc_load_splitter_checker.sv
module nc_load_splitter_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              ar_valid,
    input logic              ar_ready,
    input logic [ADDR_W-1:0] ar_addr,
    input logic [2:0]        ar_size,
    input logic [3:0]        ar_len,
    input logic              done,
    input logic [1:0]        done_count
);

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (ar_valid && !ar_ready) |=> (ar_valid && $stable(ar_addr) && $stable(ar_size) && $stable(ar_len)));

    p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (rst)
        ar_valid |-> !req_ready);

    p_accept_issues_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> ar_valid);

    p_done_after_fire_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(ar_valid && ar_ready));

    p_done_count_range_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (done_count == 2'd1 || done_count == 2'd2));

    p_len_range_r9: assert property (@(posedge clk) disable iff (rst)
        ar_valid |-> (ar_len <= 4'd2 && ar_size <= 3'd3));

endmodule

bind nc_load_splitter nc_load_splitter_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .ar_valid  (ar_valid),
    .ar_ready  (ar_ready),
    .ar_addr   (ar_addr),
    .ar_size   (ar_size),
    .ar_len    (ar_len),
    .done      (done),
    .done_count(done_count)
);

// File: tb/nc_load_splitter_tb_top.sv
module nc_load_splitter_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = 3'd0;
    logic [31:0] req_addr = 32'd0;
    logic        req_strict = 1'b0;
    logic        ar_valid;
    logic        ar_ready = 1'b0;
    logic [31:0] ar_addr;
    logic [1:0]  ar_burst;
    logic [2:0]  ar_size;
    logic [3:0]  ar_len;
    logic        done;
    logic [1:0]  done_count;

    int checks = 0;
    int errors = 0;

    logic [31:0] e_addr [2];
    logic [2:0]  e_size [2];
    logic [3:0]  e_len  [2];
    int          e_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    nc_load_splitter dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_strict(req_strict),
        .ar_valid(ar_valid), .ar_ready(ar_ready),
        .ar_addr(ar_addr), .ar_burst(ar_burst), .ar_size(ar_size), .ar_len(ar_len),
        .done(done), .done_count(done_count)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] k, input logic [31:0] a);
        case (k)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return (a[4:2] == 3'd7) ? "R5" : "R4";
            3'd4: return (a[4:2] >= 3'd6) ? "R7" : "R6";
            default: return "R1";
        endcase
    endfunction

    // Expected pieces from the requirement tables
    task automatic expect_set(input logic [2:0] k, input logic [31:0] a, input bit strict);
        logic [31:0] wa, nw, lb;
        logic [2:0] w;
        wa = {a[31:2], 2'b00};
        nw = wa + 32'd4;
        lb = {a[31:5], 5'd0};
        w  = a[4:2];
        e_n = 1; e_addr[0] = a; e_size[0] = 3'd0; e_len[0] = 4'd0;
        e_addr[1] = '0; e_size[1] = 3'd0; e_len[1] = 4'd0;
        case (k)
            3'd1: begin
                if (a[1:0] == 2'd1) e_size[0] = 3'd2;
                else if (a[1:0] == 2'd3) begin e_n = 2; e_addr[1] = nw; end
                else e_size[0] = 3'd1;
            end
            3'd2: begin
                if (a[1:0] == 2'd0) e_size[0] = 3'd2;
                else begin
                    e_n = 2; e_addr[1] = nw;
                    if (a[1:0] == 2'd1) begin e_size[0] = 3'd2; e_size[1] = 3'd0; end
                    if (a[1:0] == 2'd2) begin e_size[0] = 3'd1; e_size[1] = 3'd1; end
                    if (a[1:0] == 2'd3) begin e_size[0] = 3'd0; e_size[1] = 3'd2; end
                end
            end
            3'd3: begin
                e_addr[0] = wa;
                if (w == 3'd7) begin
                    e_n = 2; e_size[0] = 3'd2; e_addr[1] = lb; e_size[1] = 3'd2;
                end else if (w[0]) begin e_size[0] = 3'd2; e_len[0] = 4'd1; end
                else e_size[0] = 3'd3;
            end
            3'd4: begin
                e_addr[0] = wa;
                if (w == 3'd6) begin
                    e_n = 2; e_size[0] = 3'd3; e_addr[1] = lb; e_size[1] = 3'd2;
                end else if (w == 3'd7) begin
                    e_n = 2; e_size[0] = 3'd2; e_addr[1] = lb; e_size[1] = 3'd3;
                end else if (strict) begin e_size[0] = 3'd2; e_len[0] = 4'd2; end
                else begin e_size[0] = 3'd3; e_len[0] = 4'd1; end
            end
            default: ;
        endcase
    endtask

    task automatic run_req(input logic [2:0] k, input logic [31:0] a, input bit strict, input int max_stall);
        string r;
        r = req_of(k, a);
        expect_set(k, a, strict);
        @(negedge clk);
        check(req_ready == 1'b1, "R11 idle ready", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_strict = strict;
        @(negedge clk);
        req_valid = 1'b0;
        check(ar_valid == 1'b1, "R11 issue after accept", 64'(ar_valid), 64'd1);
        for (int p = 0; p < e_n; p++) begin
            int stalls;
            stalls = (max_stall > 0) ? int'($urandom % (max_stall + 1)) : 0;
            for (int s = 0; s < stalls; s++) begin
                ar_ready = 1'b0;
                @(negedge clk);
            end
            check(ar_valid == 1'b1 && req_ready == 1'b0, "R8 piece held valid", 64'({ar_valid, req_ready}), 64'b10);
            check(ar_addr == e_addr[p], {r, " addr"}, 64'(ar_addr), 64'(e_addr[p]));
            check(ar_size == e_size[p], {r, " size"}, 64'(ar_size), 64'(e_size[p]));
            check(ar_len == e_len[p], {r, " len R9"}, 64'(ar_len), 64'(e_len[p]));
            check(ar_burst == 2'b01, "R9 burst INCR", 64'(ar_burst), 64'd1);
            ar_ready = 1'b1;
            @(negedge clk);
            ar_ready = 1'b0;
        end
        check(done == 1'b1, "R10 done pulse", 64'(done), 64'd1);
        check(done_count == 2'(e_n), "R10 done count", 64'(done_count), 64'(e_n));
        check(ar_valid == 1'b0, "R8 no extra piece", 64'(ar_valid), 64'd0);
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", 64'(done), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(req_ready == 1'b1, "R11 reset ready", 64'(req_ready), 64'd1);
        check(ar_valid == 1'b0, "R11 reset ar_valid", 64'(ar_valid), 64'd0);
        check(done == 1'b0, "R11 reset done", 64'(done), 64'd0);

        // R1 byte, including unused kind codes
        for (int b = 0; b < 8; b++) run_req(3'd0, 32'h1000_0040 + 32'(b), 1'b0, 0);
        run_req(3'd5, 32'h0000_0013, 1'b0, 1);
        run_req(3'd7, 32'h0000_001F, 1'b1, 1);
        // R2 / R3 every byte position, including line-end crossing
        for (int b = 0; b < 8; b++) run_req(3'd1, 32'h2000_0100 + 32'(b), 1'b0, 1);
        for (int b = 0; b < 8; b++) run_req(3'd2, 32'h2000_0200 + 32'(b), 1'b0, 1);
        run_req(3'd2, 32'h0000_001F, 1'b0, 2);
        run_req(3'd1, 32'h0000_003F, 1'b0, 2);
        // R4 / R5 every word
        for (int w = 0; w < 8; w++) run_req(3'd3, 32'hABCD_0300 + 32'(w*4), 1'b0, 2);
        // R6 / R7 every word, both memory types
        for (int w = 0; w < 8; w++) begin
            run_req(3'd4, 32'h5555_0460 + 32'(w*4), 1'b1, 2);
            run_req(3'd4, 32'h5555_0460 + 32'(w*4), 1'b0, 2);
        end
        // Random mix
        for (int i = 0; i < 200; i++) begin
            logic [2:0] k;
            k = 3'($urandom % 8);
            run_req(k, $urandom, 1'($urandom), 3);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule